// File: doc/BRIEF.md
# LCD Frame and Alternation Timing Generator

This block produces the scan timing for a dot-matrix LCD row driver from a free-running oscillator clock. It divides the oscillator by two to make the line shift clock. It counts lines into frames of 120 or 240 lines and marks line 1 of every frame with a frame pulse. It also makes the drive-alternation signal, which inverts after every N lines. That signal can be combined by XOR with a flag that flips once per frame. A display-off line keeps the panel blank from reset until one whole frame has been scanned, and afterwards whenever the host asks for blanking.

In master mode the block drives its own timing and owns the display-off pad. In slave mode it forwards the line clock, frame pulse and alternation signal that another device supplies, releases the display-off pad, and takes the blanking state from it. The pad is split into `doc_out`, `doc_oe` and `doc_in` so that a pad cell can join them.

A four-state controller runs the master sequence. ST_WAIT is the state after reset, before any line has started. It moves to ST_FIRST on the first line-clock rise, or to ST_SLAVE when master mode is off. ST_FIRST blanks the display during the first frame. It moves to ST_LIVE when the next frame begins, or to ST_SLAVE when master mode is dropped. ST_LIVE is normal operation and moves to ST_SLAVE when master mode is dropped. ST_SLAVE forwards the external signals and returns to ST_WAIT when master mode comes back, so a new frame then starts cleanly.

Top module: `lcd_scan_timer`

## Requirements
- R1: In master mode `cl1` is low while reset is held. It goes high on the first `clk` rising edge after reset is released and then inverts on every `clk` rising edge, so its period is two `clk` cycles with equal high and low times.
- R2: `flm` is high for exactly one `cl1` period, starting at the `cl1` rise that begins line 1 of a frame. The first frame starts at the first `cl1` rise after reset.
- R3: A frame has 240 lines when `duty_full` is 1 and 120 lines when it is 0, so `flm` repeats every 480 or 240 `clk` cycles.
- R4: The line span N is `span_code` read as an unsigned number when it is 2 to 63. Codes 0 and 1 give N=2.
- R5: When `frame_xor_en` is 0, `m` is 0 during lines 1..N of every frame and inverts at the start of each following group of N lines. The count restarts at 0 at line 1 of every frame.
- R6: When `frame_xor_en` is 1, `m` is the R5 waveform XOR a frame flag. The flag is 1 during the first frame after reset and inverts at every later frame start.
- R7: In master mode `doc_oe` is 1, and `doc_out` is 1 from reset until the `cl1` rise that starts line 1 of the second frame. After that, `doc_out` equals the inverse of `dispoff_req_n`. `disp_off` equals `doc_out`.
- R8: In slave mode (`master_sel`=0) `cl1`, `flm` and `m` equal `ext_cl1`, `ext_flm` and `ext_m`, `doc_oe` is 0 and `disp_off` equals `doc_in`.
- R9: While reset is held in master mode, `flm` and `m` are 0 and `doc_out` and `disp_off` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = generate timing, 0 = forward external timing |
| duty_full | input | 1 | 1 = 240-line frame, 0 = 120-line frame |
| span_code | input | 6 | Lines per alternation group |
| frame_xor_en | input | 1 | XOR the alternation signal with the frame flag |
| dispoff_req_n | input | 1 | Active-low display-off request from the host |
| ext_cl1 | input | 1 | Line clock from the timing master (slave mode) |
| ext_flm | input | 1 | Frame pulse from the timing master (slave mode) |
| ext_m | input | 1 | Alternation signal from the timing master (slave mode) |
| doc_in | input | 1 | Display-off pad input value |
| doc_out | output | 1 | Display-off pad output value, 1 = blank |
| doc_oe | output | 1 | Display-off pad output enable |
| cl1 | output | 1 | Line shift clock |
| flm | output | 1 | Frame start pulse |
| m | output | 1 | Drive alternation signal |
| disp_off | output | 1 | Display-off state seen by the driver, 1 = blank |

## Verification
Directed runs cover span codes 0, 1, 2 and 63 with both frame lengths. Codes 0 and 1 show whether the clamp to N=2 is present. Code 63 is longer than half of a 120-line frame, so it shows whether the count restarts at the frame boundary rather than running on. Random runs then pick the frame length, span code, XOR mode and run length. Toggling the host blanking request during a run separates the forced blanking of the first frame from the host request. A slave run with random external values shows that no internal timing leaks into the forwarded signals.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_FIRST = 2'd1,
        ST_LIVE  = 2'd2,
        ST_SLAVE = 2'd3
    } scan_state_t;

    localparam int LINES_LONG  = 240;
    localparam int LINES_SHORT = 120;
    localparam int SPAN_BITS   = 6;
    localparam int SPAN_FLOOR  = 2;

endpackage

// File: rtl/lcd_line_clock.sv
module lcd_line_clock (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic cl1_q,
    output logic rise
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cl1_q <= 1'b0;
        end else if (!run_en) begin
            cl1_q <= 1'b0;
        end else begin
            cl1_q <= ~cl1_q;
        end
    end

    // A rise happens on the coming edge when the clock is low and enabled
    assign rise = run_en & ~cl1_q;

    // R1: while running, the line clock inverts on every edge
    a_r1_cl1_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (cl1_q != $past(cl1_q)));

endmodule

// File: rtl/lcd_frame_counter.sv
module lcd_frame_counter #(
    parameter int LINES_MAX = 240,
    parameter int LINES_MIN = 120,
    localparam int LW = $clog2(LINES_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          restart,
    input  logic          duty_full,
    output logic [LW-1:0] line_no,
    output logic          flm_q,
    output logic          frame_flag,
    output logic          frame_start
);

    localparam logic [LW-1:0] LEN_LONG  = LW'(LINES_MAX);
    localparam logic [LW-1:0] LEN_SHORT = LW'(LINES_MIN);

    logic [LW-1:0] frame_len;

    always_comb begin
        frame_len   = duty_full ? LEN_LONG : LEN_SHORT;
        frame_start = rise & (restart | (line_no >= frame_len));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_no    <= '0;
            flm_q      <= 1'b0;
            frame_flag <= 1'b0;
        end else if (frame_start) begin
            line_no    <= LW'(1);
            flm_q      <= 1'b1;
            frame_flag <= ~frame_flag;
        end else if (rise) begin
            line_no    <= line_no + LW'(1);
            flm_q      <= 1'b0;
        end
    end

    // R3: the line index never runs past the longest frame
    a_r3_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        line_no <= LEN_LONG);

    // R2: the frame pulse only starts on a line clock rise
    a_r2_flm_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flm_q) |-> $past(rise));

endmodule

// File: rtl/lcd_alt_gen.sv
module lcd_alt_gen #(
    parameter int CODE_W = 6,
    parameter int N_MIN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              frame_start,
    input  logic [CODE_W-1:0] span_code,
    input  logic              frame_flag,
    input  logic              xor_en,
    output logic              m_int
);

    logic [CODE_W-1:0] n_eff;
    logic [CODE_W-1:0] grp_cnt;
    logic              line_ph;

    always_comb begin
        n_eff = (span_code < CODE_W'(N_MIN)) ? CODE_W'(N_MIN) : span_code;
        m_int = line_ph ^ (xor_en & frame_flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_cnt <= '0;
            line_ph <= 1'b0;
        end else if (frame_start) begin
            grp_cnt <= CODE_W'(1);
            line_ph <= 1'b0;
        end else if (rise) begin
            if (grp_cnt >= n_eff) begin
                grp_cnt <= CODE_W'(1);
                line_ph <= ~line_ph;
            end else begin
                grp_cnt <= grp_cnt + CODE_W'(1);
            end
        end
    end

    // R5: the line phase changes only at a line clock rise
    a_r5_phase_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_ph) |-> $past(rise));

    // R5: a frame start always leaves the phase at zero
    a_r5_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !line_ph);

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_scan_pkg::*;
#(
    parameter int LINES_MAX = LINES_LONG,
    parameter int LINES_MIN = LINES_SHORT,
    parameter int CODE_W    = SPAN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              duty_full,
    input  logic [CODE_W-1:0] span_code,
    input  logic              frame_xor_en,
    input  logic              dispoff_req_n,
    input  logic              ext_cl1,
    input  logic              ext_flm,
    input  logic              ext_m,
    input  logic              doc_in,
    output logic              doc_out,
    output logic              doc_oe,
    output logic              cl1,
    output logic              flm,
    output logic              m,
    output logic              disp_off
);

    localparam int LW = $clog2(LINES_MAX + 1);

    scan_state_t   state_q, state_d;
    logic          run_en, cl1_q, rise;
    logic [LW-1:0] line_no;
    logic          flm_q, frame_flag, frame_start, m_int;

    assign run_en = master_sel & (state_q != ST_SLAVE);

    lcd_line_clock u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run_en(run_en),
        .cl1_q (cl1_q),
        .rise  (rise)
    );

    lcd_frame_counter #(
        .LINES_MAX(LINES_MAX),
        .LINES_MIN(LINES_MIN)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .restart    (state_q == ST_WAIT),
        .duty_full  (duty_full),
        .line_no    (line_no),
        .flm_q      (flm_q),
        .frame_flag (frame_flag),
        .frame_start(frame_start)
    );

    lcd_alt_gen #(
        .CODE_W(CODE_W),
        .N_MIN (SPAN_FLOOR)
    ) u_alt (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .frame_start(frame_start),
        .span_code  (span_code),
        .frame_flag (frame_flag),
        .xor_en     (frame_xor_en),
        .m_int      (m_int)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (!master_sel)      state_d = ST_SLAVE;
                else if (rise)        state_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (!master_sel)      state_d = ST_SLAVE;
                else if (frame_start) state_d = ST_LIVE;
            end
            ST_LIVE: begin
                if (!master_sel)      state_d = ST_SLAVE;
            end
            ST_SLAVE: begin
                if (master_sel)       state_d = ST_WAIT;
            end
            default:                  state_d = ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        if (master_sel) begin
            cl1      = cl1_q;
            flm      = flm_q;
            m        = m_int;
            doc_oe   = 1'b1;
            doc_out  = (state_q != ST_LIVE) | ~dispoff_req_n;
            disp_off = doc_out;
        end else begin
            cl1      = ext_cl1;
            flm      = ext_flm;
            m        = ext_m;
            doc_oe   = 1'b0;
            doc_out  = 1'b0;
            disp_off = doc_in;
        end
    end

    // R7: blanking is released only when a new frame begins
    a_r7_live_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_LIVE) |-> flm_q);

    // R7: the live state is reached only through the first frame
    a_r7_first_before_live: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_LIVE) |-> ($past(state_q) == ST_FIRST));

    // R2: frame pulse lasts one line clock period
    a_r2_flm_width: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && $rose(flm_q)) |=> flm_q);

endmodule

// File: tb/lcd_scan_timer_test.sv
module lcd_scan_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_sel = 1'b1;
    logic       duty_full = 1'b1;
    logic [5:0] span_code = 6'd2;
    logic       frame_xor_en = 1'b0;
    logic       dispoff_req_n = 1'b1;
    logic       ext_cl1 = 1'b0, ext_flm = 1'b0, ext_m = 1'b0, doc_in = 1'b0;
    logic       doc_out, doc_oe, cl1, flm, m, disp_off;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lcd_scan_timer uut (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .duty_full(duty_full),
        .span_code(span_code), .frame_xor_en(frame_xor_en), .dispoff_req_n(dispoff_req_n),
        .ext_cl1(ext_cl1), .ext_flm(ext_flm), .ext_m(ext_m), .doc_in(doc_in),
        .doc_out(doc_out), .doc_oe(doc_oe), .cl1(cl1), .flm(flm), .m(m), .disp_off(disp_off)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Expected outputs after e clock edges since reset release (master mode)
    function automatic int span_of(input int code);
        return (code < 2) ? 2 : code;
    endfunction

    function automatic logic [2:0] model(input int e, input int lines, input int n, input bit xr);
        int t, li, f;
        logic c, fl, mm;
        if (e == 0) return 3'b000;
        t  = (e + 1) / 2;
        li = (t - 1) % lines;
        f  = (t - 1) / lines;
        c  = (e % 2) == 1;
        fl = (li == 0);
        mm = ((li / n) % 2) == 1;
        if (xr) mm = mm ^ ((f % 2) == 0);
        return {c, fl, mm};
    endfunction

    function automatic logic model_doc(input int e, input int lines, input bit req_n);
        int t;
        t = (e + 1) / 2;
        return (t < lines + 1) || !req_n;
    endfunction

    task automatic run_master(input bit dfull, input int code, input bit xr, input int edges, input bit wiggle);
        int lines, n;
        logic [2:0] exp;
        lines = dfull ? 240 : 120;
        n = span_of(code);
        @(negedge clk);
        rst_n = 1'b0;
        master_sel = 1'b1;
        duty_full = dfull;
        span_code = 6'(code);
        frame_xor_en = xr;
        dispoff_req_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 reset state
        check("R9", "flm in reset", flm, 1'b0);
        check("R9", "m in reset", m, 1'b0);
        check("R1", "cl1 in reset", cl1, 1'b0);
        check("R9", "doc_out in reset", doc_out, 1'b1);
        check("R9", "disp_off in reset", disp_off, 1'b1);
        rst_n = 1'b1;
        for (int e = 1; e <= edges; e++) begin
            @(negedge clk);
            exp = model(e, lines, n, xr);
            check("R1", "cl1", cl1, exp[2]);
            check((e <= 2) ? "R2" : "R3", "flm", flm, exp[1]);
            check(xr ? "R6" : ((code < 2) ? "R4" : "R5"), "m", m, exp[0]);
            check("R7", "doc_out", doc_out, model_doc(e, lines, dispoff_req_n));
            check("R7", "disp_off", disp_off, model_doc(e, lines, dispoff_req_n));
            check("R7", "doc_oe", doc_oe, 1'b1);
            if (wiggle && ($urandom % 97 == 0)) begin
                dispoff_req_n = ~dispoff_req_n;
                #1;
                check("R7", "doc_out after request change", doc_out, model_doc(e, lines, dispoff_req_n));
            end
        end
    endtask

    task automatic run_slave(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        master_sel = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            {ext_cl1, ext_flm, ext_m, doc_in} = 4'($urandom);
            #1;
            check("R8", "cl1 pass", cl1, ext_cl1);
            check("R8", "flm pass", flm, ext_flm);
            check("R8", "m pass", m, ext_m);
            check("R8", "doc_oe", doc_oe, 1'b0);
            check("R8", "disp_off from pad", disp_off, doc_in);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Directed corners: clamp codes, shortest span, long span over a short frame
        run_master(1'b0, 0, 1'b0, 600, 1'b0);
        run_master(1'b0, 1, 1'b1, 600, 1'b0);
        run_master(1'b1, 2, 1'b0, 1100, 1'b0);
        run_master(1'b0, 63, 1'b0, 700, 1'b0);
        run_master(1'b1, 63, 1'b1, 1100, 1'b1);
        run_master(1'b0, 7, 1'b1, 800, 1'b1);
        // Random configurations
        for (int k = 0; k < 12; k++) begin
            run_master(1'($urandom), int'($urandom % 64), 1'($urandom),
                       600 + int'($urandom % 700), 1'b1);
        end
        run_slave(200);
        // Returning to master after slave restarts a clean sequence
        run_master(1'b1, 5, 1'b1, 1000, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule